// File: doc/BRIEF.md
# Byte ALU with Overflow/Logic Flag

The block is the byte-wide execute stage of a small accumulator datapath. A first operand (the accumulator), a second operand, a carry input and a five-bit operation code enter it. The result leaves it combinationally, in the same cycle, together with a write-back strobe. The four condition flags are held in a register that loads on the next rising clock edge. Operand fetch, address generation and instruction decode sit outside the block.

One flag bit has two meanings. After an arithmetic operation it reports two's-complement overflow. After a bitwise, shift or rotate operation it reports whether any bit in the upper half of the result is set. Carry also follows two conventions. Plain subtract reports "no borrow". Subtract-with-borrow, compare and negate report "borrow". Increment and decrement leave carry alone. Complement and unassigned codes leave every flag alone.

Top module: `alu8_core`

## Requirements
- R1: Code 0 (add) returns a+b and code 1 (add with carry) returns a+b+cin. C is the carry out of bit 7. LV is set when both operands have the same sign and the result has the other sign.
- R2: Code 2 (subtract) returns a-b. C is 1 when a >= b and 0 when a < b. LV is signed overflow of a-b.
- R3: Code 3 (subtract with borrow) returns a-b-cin. C is 1 when a < b+cin. LV is signed overflow.
- R4: Code 4 (compare) drives res_we_o low. It updates all four flags as for a-b, with C = 1 when a < b.
- R5: Codes 8, 9 and 10 (AND, OR, XOR) return the bitwise result, clear C, and set LV to 1 exactly when any of result bits 7..4 is 1.
- R6: Rotates set LV from result bits 7..4. Code 12 moves bit 7 to bit 0 and to C. Code 13 moves bit 0 to bit 7 and to C. Code 14 shifts left with cin into bit 0 and bit 7 into C. Code 15 shifts right with cin into bit 7 and bit 0 into C.
- R7: Shifts set LV from result bits 7..4. Code 16 shifts left with a 0 into bit 0 and bit 7 into C. Code 17 shifts right, keeps bit 7 and sends bit 0 to C. Code 18 shifts right with a 0 into bit 7 and bit 0 into C.
- R8: Code 6 (increment) and code 7 (decrement) return a+1 and a-1. They set LV on signed overflow (a=0x7F and a=0x80 respectively) and keep C at its previous registered value.
- R9: Code 5 (negate) returns 0-a. C is 1 when a is non-zero. LV is 1 only for a=0x80.
- R10: Code 11 (complement) returns ~a with res_we_o high and leaves all four flags unchanged.
- R11: For every flag-updating code, Z is 1 when the 8-bit result is zero and S equals result bit 7.
- R12: Codes 19 to 31 return a unchanged, drive res_we_o low and leave all flags unchanged.
- R13: While rst is high at a rising edge, the flag register clears to 0.
- R14: flags_o = {S, Z, LV, C} (bit 3 down to bit 0). It changes only at the rising edge that follows the operation. res_o and res_we_o respond within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand (accumulator) |
| b_i | input | 8 | Second operand |
| cin_i | input | 1 | Carry input for add-with-carry, subtract-with-borrow and carry rotates |
| res_o | output | 8 | Combinational result |
| res_we_o | output | 1 | High when the result is meant to be written back |
| flags_o | output | 4 | Registered flags {S, Z, LV, C} |

## Verification
The critical overlap is a flag-preserving operation in the same cycle as the flag register takes its previous update. An increment or decrement must write new S, Z and LV but keep the carry produced by the operation just before it. Complement and unassigned codes must keep all four bits. The bench provokes this by issuing such codes back to back, with no idle cycle, directly after carry-setting and carry-clearing operations. It then compares the registered flags one edge later with a model that carries the previous flags forward. The bench also samples the flags just before each edge, to show that the combinational result never leaks into the flag register early.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    parameter int unsigned DW = 8;
    localparam int unsigned MSB = DW - 1;
    localparam int unsigned HALF = DW / 2;

    typedef logic [DW-1:0] word_t;

    typedef enum logic [4:0] {
        OP_ADD = 5'd0,
        OP_ADC = 5'd1,
        OP_SUB = 5'd2,
        OP_SBC = 5'd3,
        OP_CP  = 5'd4,
        OP_NEG = 5'd5,
        OP_INC = 5'd6,
        OP_DEC = 5'd7,
        OP_AND = 5'd8,
        OP_OR  = 5'd9,
        OP_XOR = 5'd10,
        OP_CPL = 5'd11,
        OP_RLC = 5'd12,
        OP_RRC = 5'd13,
        OP_RL  = 5'd14,
        OP_RR  = 5'd15,
        OP_SLA = 5'd16,
        OP_SRA = 5'd17,
        OP_SRL = 5'd18
    } op_e;

    typedef enum logic [1:0] {
        CL_ARITH,
        CL_BITWISE,
        CL_SHIFT,
        CL_NONE
    } class_e;

    typedef struct packed {
        logic s;
        logic z;
        logic lv;
        logic c;
    } flags_t;

    typedef struct packed {
        word_t res;
        logic  c;
        logic  v;
    } arith_t;

    typedef struct packed {
        word_t res;
        logic  c;
    } shift_t;

    function automatic class_e op_class(input logic [4:0] code);
        if (code <= OP_DEC)      return CL_ARITH;
        else if (code <= OP_CPL) return CL_BITWISE;
        else if (code <= OP_SRL) return CL_SHIFT;
        else                     return CL_NONE;
    endfunction

    function automatic logic upper_any(input word_t r);
        return |r[MSB:HALF];
    endfunction

    function automatic logic is_zero(input word_t r);
        return r == '0;
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
(
    input  op_e    op,
    input  word_t  a,
    input  word_t  b,
    input  logic   cin,
    output arith_t out
);

    localparam int unsigned WW = DW + 1;

    word_t         x;
    word_t         y;
    logic          sub_mode;
    logic          ci;
    logic [WW-1:0] wide;

    // Operand steering: one adder/subtractor serves every arithmetic code.
    always_comb begin
        x        = a;
        y        = b;
        sub_mode = 1'b0;
        ci       = 1'b0;
        case (op)
            OP_ADD: ;
            OP_ADC: ci = cin;
            OP_SUB,
            OP_CP:  sub_mode = 1'b1;
            OP_SBC: begin
                sub_mode = 1'b1;
                ci       = cin;
            end
            OP_NEG: begin
                x        = '0;
                y        = a;
                sub_mode = 1'b1;
            end
            OP_INC: y = word_t'(1);
            OP_DEC: begin
                y        = word_t'(1);
                sub_mode = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        if (sub_mode)
            wide = {1'b0, x} - {1'b0, y} - WW'(ci);
        else
            wide = {1'b0, x} + {1'b0, y} + WW'(ci);
    end

    // wide[DW] is carry for additions and borrow for subtractions.
    // Plain subtract reports the inverse of borrow.
    always_comb begin
        out.res = wide[MSB:0];
        if (sub_mode)
            out.v = (x[MSB] != y[MSB]) && (wide[MSB] != x[MSB]);
        else
            out.v = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);
        out.c = (op == OP_SUB) ? ~wide[DW] : wide[DW];
    end

endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
(
    input  op_e   op,
    input  word_t a,
    input  word_t b,
    output word_t res
);

    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_CPL:  res = ~a;
            default: res = a;
        endcase
    end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
(
    input  op_e    op,
    input  word_t  a,
    input  logic   cin,
    output shift_t out
);

    logic fill_lo;
    logic fill_hi;

    // Bit entering the vacated end for left and right moves.
    always_comb begin
        case (op)
            OP_RLC:  fill_lo = a[MSB];
            OP_RL:   fill_lo = cin;
            default: fill_lo = 1'b0;
        endcase
        case (op)
            OP_RRC:  fill_hi = a[0];
            OP_RR:   fill_hi = cin;
            OP_SRA:  fill_hi = a[MSB];
            default: fill_hi = 1'b0;
        endcase
    end

    always_comb begin
        case (op)
            OP_RLC, OP_RL, OP_SLA: begin
                out.res = {a[MSB-1:0], fill_lo};
                out.c   = a[MSB];
            end
            OP_RRC, OP_RR, OP_SRA, OP_SRL: begin
                out.res = {fill_hi, a[MSB:1]};
                out.c   = a[0];
            end
            default: begin
                out.res = a;
                out.c   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [4:0]    op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    output logic [DW-1:0] res_o,
    output logic          res_we_o,
    output logic [3:0]    flags_o
);

    op_e    op;
    class_e cls;
    arith_t ar;
    word_t  bw;
    shift_t sh;
    word_t  res;
    logic   we;
    flags_t flg_d;
    flags_t flg_q;

    assign op  = op_e'(op_i);
    assign cls = op_class(op_i);

    alu8_arith u_arith (
        .op  (op),
        .a   (a_i),
        .b   (b_i),
        .cin (cin_i),
        .out (ar)
    );

    alu8_bitwise u_bitwise (
        .op  (op),
        .a   (a_i),
        .b   (b_i),
        .res (bw)
    );

    alu8_shift u_shift (
        .op  (op),
        .a   (a_i),
        .cin (cin_i),
        .out (sh)
    );

    // Result select and next-flag formation.
    always_comb begin
        res   = a_i;
        we    = 1'b0;
        flg_d = flg_q;
        case (cls)
            CL_ARITH: begin
                res      = ar.res;
                we       = (op != OP_CP);
                flg_d.s  = ar.res[MSB];
                flg_d.z  = is_zero(ar.res);
                flg_d.lv = ar.v;
                flg_d.c  = (op == OP_INC || op == OP_DEC) ? flg_q.c : ar.c;
            end
            CL_BITWISE: begin
                res = bw;
                we  = 1'b1;
                if (op != OP_CPL) begin
                    flg_d.s  = bw[MSB];
                    flg_d.z  = is_zero(bw);
                    flg_d.lv = upper_any(bw);
                    flg_d.c  = 1'b0;
                end
            end
            CL_SHIFT: begin
                res      = sh.res;
                we       = 1'b1;
                flg_d.s  = sh.res[MSB];
                flg_d.z  = is_zero(sh.res);
                flg_d.lv = upper_any(sh.res);
                flg_d.c  = sh.c;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            flg_q <= '0;
        else
            flg_q <= flg_d;
    end

    assign res_o    = res;
    assign res_we_o = we;
    assign flags_o  = flg_q;

    // ---------------- assertions ----------------
    a_r13_reset_clears: assert property (@(posedge clk)
        rst |=> (flags_o == 4'b0000));

    a_r5_bitwise_clears_carry: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) |=> (flags_o[0] == 1'b0));

    a_r8_incdec_keeps_carry: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_INC || op_i == OP_DEC) |=> (flags_o[0] == $past(flags_o[0])));

    a_r10_cpl_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CPL) |=> $stable(flags_o));

    a_r12_unused_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        (op_i > OP_SRL) |=> $stable(flags_o));

    a_r12_unused_passes: assert property (@(posedge clk) disable iff (rst)
        (op_i > OP_SRL) |-> (res_o == a_i && !res_we_o));

    a_r4_cp_no_writeback: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CP) |-> !res_we_o);

    a_r11_zero_flag: assert property (@(posedge clk) disable iff (rst)
        (op_i <= OP_SRL && op_i != OP_CPL) |=> (flags_o[2] == ($past(res_o) == '0)));

    a_r7_sra_keeps_sign: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SRA) |-> (res_o[MSB] == a_i[MSB]));

endmodule

// File: tb/test_alu8_core.sv
module test_alu8_core;

    logic       clk;
    logic       rst;
    logic [4:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic       cin;
    logic [7:0] res_o;
    logic       res_we_o;
    logic [3:0] flags_o;

    int checks = 0;
    int errors = 0;
    logic [3:0] mflags;

    alu8_core i_alu8_core (
        .clk      (clk),
        .rst      (rst),
        .op_i     (op),
        .a_i      (a),
        .b_i      (b),
        .cin_i    (cin),
        .res_o    (res_o),
        .res_we_o (res_we_o),
        .flags_o  (flags_o)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int sx(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    function automatic bit out_of_range(input int s);
        return (s > 127) || (s < -128);
    endfunction

    // Reference model written from the requirement list.
    task automatic model(input int o, input int x, input int y, input int ci,
                         input logic [3:0] pf, output int r, output bit we,
                         output logic [3:0] nf);
        bit c, v, upd;
        c = pf[0]; v = 1'b0; upd = 1'b1; we = 1'b1; r = x;
        case (o)
            0:  begin r = (x + y) & 255;      c = (x + y) > 255;      v = out_of_range(sx(x) + sx(y)); end
            1:  begin r = (x + y + ci) & 255; c = (x + y + ci) > 255; v = out_of_range(sx(x) + sx(y) + ci); end
            2:  begin r = (x - y) & 255;      c = (x >= y);           v = out_of_range(sx(x) - sx(y)); end
            3:  begin r = (x - y - ci) & 255; c = (x < y + ci);       v = out_of_range(sx(x) - sx(y) - ci); end
            4:  begin r = (x - y) & 255;      c = (x < y);            v = out_of_range(sx(x) - sx(y)); we = 1'b0; end
            5:  begin r = (256 - x) & 255;    c = (x != 0);           v = (x == 128); end
            6:  begin r = (x + 1) & 255;      v = (x == 127); end
            7:  begin r = (x + 255) & 255;    v = (x == 128); end
            8:  begin r = x & y; c = 0; end
            9:  begin r = x | y; c = 0; end
            10: begin r = x ^ y; c = 0; end
            11: begin r = (~x) & 255; upd = 1'b0; end
            12: begin r = ((x << 1) | (x >> 7)) & 255; c = (x >> 7) & 1; end
            13: begin r = (x >> 1) | ((x & 1) << 7);   c = x & 1; end
            14: begin r = ((x << 1) | ci) & 255;       c = (x >> 7) & 1; end
            15: begin r = (x >> 1) | (ci << 7);        c = x & 1; end
            16: begin r = (x << 1) & 255;              c = (x >> 7) & 1; end
            17: begin r = (x >> 1) | (x & 128);        c = x & 1; end
            18: begin r = x >> 1;                      c = x & 1; end
            default: begin r = x; we = 1'b0; upd = 1'b0; end
        endcase
        if (o >= 8 && o <= 18) v = (r >= 16);
        if (upd) nf = {r >= 128, r == 0, v, c};
        else     nf = pf;
    endtask

    // Issue one operation, check combinational outputs and next flags.
    task automatic run_op(input string tag, input int o, input int x, input int y, input int ci);
        int r; bit we; logic [3:0] nf;
        @(negedge clk);
        op = 5'(o); a = 8'(x); b = 8'(y); cin = ci[0];
        model(o, x, y, ci, mflags, r, we, nf);
        #5;
        check(tag, "result", int'(res_o), r);
        check(tag, "write enable", int'(res_we_o), int'(we));
        check("R14", "flags before edge", int'(flags_o), int'(mflags));
        @(posedge clk);
        #5;
        check(tag, "flags", int'(flags_o), int'(nf));
        mflags = nf;
    endtask

    task automatic t_reset();
        rst = 1'b1; op = 5'd31; a = 8'h00; b = 8'h00; cin = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        check("R13", "flags in reset", int'(flags_o), 0);
        @(negedge clk);
        rst = 1'b0;
        mflags = 4'b0000;
    endtask

    task automatic t_add();
        run_op("R1", 0, 8'h7F, 8'h01, 0);
        run_op("R1", 0, 8'hFF, 8'h01, 0);
        run_op("R1", 1, 8'h10, 8'h20, 1);
        run_op("R1", 1, 8'hFF, 8'h00, 1);
    endtask

    task automatic t_sub();
        run_op("R2", 2, 5, 3, 1);
        run_op("R2", 2, 3, 5, 0);
        run_op("R2", 2, 8'h80, 8'h01, 0);
        run_op("R2", 2, 8'h42, 8'h42, 0);
    endtask

    task automatic t_sbc_cp();
        run_op("R3", 3, 5, 5, 1);
        run_op("R3", 3, 5, 4, 1);
        run_op("R3", 3, 8'h80, 8'h00, 1);
        run_op("R4", 4, 3, 5, 1);
        run_op("R4", 4, 8'h55, 8'h55, 0);
    endtask

    task automatic t_logic();
        run_op("R5", 3, 0, 1, 0);
        run_op("R5", 8, 8'hF0, 8'h3C, 0);
        run_op("R5", 9, 8'h05, 8'h02, 0);
        run_op("R11", 10, 8'hFF, 8'hFF, 0);
        run_op("R11", 9, 8'h80, 8'h00, 0);
    endtask

    task automatic t_rotate();
        run_op("R6", 12, 8'h81, 0, 0);
        run_op("R6", 13, 8'h01, 0, 0);
        run_op("R6", 14, 8'h80, 0, 0);
        run_op("R6", 15, 8'h02, 0, 1);
        run_op("R6", 14, 8'h01, 0, 1);
    endtask

    task automatic t_shift();
        run_op("R7", 16, 8'hC0, 0, 1);
        run_op("R7", 17, 8'h81, 0, 0);
        run_op("R7", 18, 8'h81, 0, 1);
        run_op("R7", 18, 8'h10, 0, 0);
    endtask

    task automatic t_incdec();
        run_op("R8", 0, 8'hFF, 8'h01, 0);
        run_op("R8", 6, 8'h7F, 0, 0);
        run_op("R8", 7, 8'h80, 0, 0);
        run_op("R8", 8, 8'h00, 8'h00, 0);
        run_op("R8", 7, 8'h00, 0, 1);
        run_op("R8", 6, 8'hFF, 0, 1);
    endtask

    task automatic t_neg();
        run_op("R9", 5, 8'h01, 0, 0);
        run_op("R9", 5, 8'h80, 0, 0);
        run_op("R9", 5, 8'h00, 0, 1);
    endtask

    task automatic t_cpl();
        run_op("R10", 2, 3, 5, 0);
        run_op("R10", 11, 8'h5A, 0, 1);
        run_op("R10", 11, 8'hFF, 0, 0);
    endtask

    task automatic t_unused();
        run_op("R12", 0, 8'hFF, 8'h01, 0);
        run_op("R12", 19, 8'h3C, 8'hAA, 1);
        run_op("R12", 31, 8'h00, 8'h11, 0);
        run_op("R12", 25, 8'h80, 8'h80, 1);
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_sbc_cp();
        t_logic();
        t_rotate();
        t_shift();
        t_incdec();
        t_neg();
        t_cpl();
        t_unused();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule